// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits behind the receive path of an Ethernet MAC and decides, for each incoming frame, whether the frame should be kept. It watches the six destination-address bytes as they arrive, one byte per strobe, and keeps a running CRC-32 over them. It also keeps the whole address. After the sixth byte it gives a verdict: keep or drop, plus flags that mark a kept frame as broadcast or multicast.

A kept frame is one that matches one of these cases:
- promiscuous mode is on;
- the frame is a broadcast that is not being rejected;
- the frame is a unicast to the programmed station address;
- the frame's address hashes to a set bit in one of two 64-entry tables. One table serves multicast (group) addresses. The other serves unicast addresses that miss the station address.

Software programs the station address, both tables and the mode bits through a simple select/data write port.

Top module: `rx_addr_filter`

## Requirements
- R1: Byte 0 of the address is the first byte accepted after `frame_start`, and bytes fill in arrival order. Bit 0 of byte 0 is the group bit. Strobed bytes after the sixth are ignored until the next `frame_start`.
- R2: `dec_valid` rises in the clock cycle after the edge that samples the sixth byte. It is low before that. It and the verdict outputs hold their values until a `frame_start`, which clears them at the next edge.
- R3: A unicast address (group bit 0) equal to the programmed station address is kept whatever both tables hold.
- R4: The hash index is bits [31:26] of a CRC-32 register. The register starts at all ones and takes the six bytes in order, each byte least significant bit first, with the reflected polynomial 0xEDB88320. No final inversion is applied.
- R5: An address with the group bit set that is not broadcast is kept only if the group table bit at the hash index is 1. Indices 0–31 are bits 0–31 of the group low word, and indices 32–63 are bits 0–31 of the group high word. The individual table plays no part.
- R6: A unicast address that differs from the station address is kept only if the individual table bit at the hash index is 1, using the same split between low and high words.
- R7: When promiscuous mode is set, every frame is kept.
- R8: The all-ones address is kept unless broadcast reject is set. Broadcast reject has no effect while promiscuous mode is set.
- R9: `bcast_flag` is 1 only for a kept all-ones address. `mcast_flag` is 1 only for a kept non-broadcast group address. Both are 0 for a dropped frame.
- R10: A write with `cfg_we` stores `cfg_wdata` into the register chosen by `cfg_sel`:
  - 0: station low word, with byte 0 in [31:24], byte 1 in [23:16], byte 2 in [15:8] and byte 3 in [7:0];
  - 1: station high word, with byte 4 in [31:24] and byte 5 in [23:16];
  - 2: individual table low word;
  - 3: individual table high word;
  - 4: group table low word;
  - 5: group table high word;
  - 6: control, with bit 0 for promiscuous mode and bit 1 for broadcast reject.

  Select 7 is ignored. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start of a new frame; restarts address capture |
| addr_valid | input | 1 | Strobe for `addr_byte` |
| addr_byte | input | 8 | Destination address byte |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Verdict valid |
| accept | output | 1 | Keep the frame |
| bcast_flag | output | 1 | Kept frame is broadcast |
| mcast_flag | output | 1 | Kept frame is multicast |

## Verification
The verdict passes through one register after the edge that samples the sixth byte. The bench drives inputs on falling edges, so it checks `dec_valid` low at the falling edge where it presents the sixth byte, and checks `dec_valid` and the verdict at the next falling edge. Stray bytes are fed after the verdict and the outputs are checked again one falling edge later, which tests that the verdict holds. A frame start cleared by the next edge is seen at the falling edge that follows. Configuration writes are finished at least one cycle before the frame whose verdict depends on them.

// File: rtl/afl_pkg.sv
package afl_pkg;
   typedef enum logic [2:0] {
      SEL_STA_LO = 3'd0,
      SEL_STA_HI = 3'd1,
      SEL_IND_LO = 3'd2,
      SEL_IND_HI = 3'd3,
      SEL_GRP_LO = 3'd4,
      SEL_GRP_HI = 3'd5,
      SEL_CTRL   = 3'd6
   } cfg_sel_e;

   typedef struct packed {
      logic prom;
      logic bc_rej;
   } ctrl_t;

   typedef struct packed {
      logic accept;
      logic bcast;
      logic mcast;
   } verdict_t;
endpackage

// File: rtl/afl_crc_step.sv
// One data word folded into a reflected CRC, one stage per bit.
module afl_crc_step #(
   parameter int CRC_W = 32,
   parameter int DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [DATA_W:0][CRC_W-1:0] stage;

   assign stage[0] = crc_i;
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign stage[b+1] = (stage[b] >> 1) ^ ({CRC_W{stage[b][0] ^ data_i[b]}} & POLY);
   end
   assign crc_o = stage[DATA_W];
endmodule

// File: rtl/afl_collect.sv
// Gathers address bytes and the running CRC; exposes the next-state view.
module afl_collect #(
   parameter int BYTES = 6,
   parameter int CRC_W = 32,
   parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               valid_i,
   input  logic [7:0]         byte_i,
   output logic               last_o,
   output logic [8*BYTES-1:0] addr_o,
   output logic [CRC_W-1:0]   crc_o
);
   localparam int CNT_W = $clog2(BYTES + 1);

   logic [CNT_W-1:0]   cnt_q, base_cnt, cnt_nx;
   logic [8*BYTES-1:0] addr_q, base_addr, addr_nx;
   logic [CRC_W-1:0]   crc_q, base_crc, crc_step, crc_nx;
   logic               take;

   assign base_cnt  = start_i ? '0 : cnt_q;
   assign base_crc  = start_i ? '1 : crc_q;
   assign base_addr = start_i ? '0 : addr_q;
   assign take      = valid_i && (base_cnt < CNT_W'(BYTES));

   afl_crc_step #(.CRC_W(CRC_W), .DATA_W(8), .POLY(POLY)) u_step (
      .crc_i (base_crc),
      .data_i(byte_i),
      .crc_o (crc_step)
   );

   for (genvar k = 0; k < BYTES; k++) begin : g_slot
      assign addr_nx[8*k +: 8] = (take && base_cnt == CNT_W'(k)) ? byte_i : base_addr[8*k +: 8];
   end

   assign crc_nx = take ? crc_step : base_crc;
   assign cnt_nx = take ? base_cnt + 1'b1 : base_cnt;
   assign last_o = take && (base_cnt == CNT_W'(BYTES - 1));
   assign addr_o = addr_nx;
   assign crc_o  = crc_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
         crc_q  <= '1;
      end else begin
         cnt_q  <= cnt_nx;
         addr_q <= addr_nx;
         crc_q  <= crc_nx;
      end
   end
endmodule

// File: rtl/afl_regs.sv
// Configuration storage: station address, two hash tables, mode bits.
module afl_regs
   import afl_pkg::*;
#(
   parameter int BYTES = 6,
   parameter int CFG_W = 32,
   parameter int SEL_W = 3,
   parameter int TBL   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [CFG_W-1:0]   wdata_i,
   output logic [8*BYTES-1:0] station_o,
   output logic [TBL-1:0]     ind_tbl_o,
   output logic [TBL-1:0]     grp_tbl_o,
   output ctrl_t              ctrl_o
);
   localparam int BPW = CFG_W / 8;

   logic [CFG_W-1:0] ind_lo_q, ind_hi_q, grp_lo_q, grp_hi_q;
   ctrl_t            ctrl_q;

   for (genvar k = 0; k < BYTES; k++) begin : g_sta
      localparam int WORD = k / BPW;
      localparam int POS  = CFG_W - 1 - 8 * (k % BPW);
      localparam logic [SEL_W-1:0] MY_SEL = (WORD == 0) ? SEL_W'(SEL_STA_LO) : SEL_W'(SEL_STA_HI);
      logic [7:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          byte_q <= '0;
         else if (we_i && sel_i == MY_SEL)    byte_q <= wdata_i[POS -: 8];
      end
      assign station_o[8*k +: 8] = byte_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ind_lo_q <= '0;
         ind_hi_q <= '0;
         grp_lo_q <= '0;
         grp_hi_q <= '0;
         ctrl_q   <= '0;
      end else if (we_i) begin
         if (sel_i == SEL_W'(SEL_IND_LO)) ind_lo_q <= wdata_i;
         if (sel_i == SEL_W'(SEL_IND_HI)) ind_hi_q <= wdata_i;
         if (sel_i == SEL_W'(SEL_GRP_LO)) grp_lo_q <= wdata_i;
         if (sel_i == SEL_W'(SEL_GRP_HI)) grp_hi_q <= wdata_i;
         if (sel_i == SEL_W'(SEL_CTRL)) begin
            ctrl_q.prom   <= wdata_i[0];
            ctrl_q.bc_rej <= wdata_i[1];
         end
      end
   end

   assign ind_tbl_o = {ind_hi_q, ind_lo_q};
   assign grp_tbl_o = {grp_hi_q, grp_lo_q};
   assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/afl_decide.sv
// Combinational verdict from a complete address and its CRC.
module afl_decide
   import afl_pkg::*;
#(
   parameter int BYTES     = 6,
   parameter int CRC_W     = 32,
   parameter int HASH_BITS = 6,
   parameter int TBL       = 64
) (
   input  logic [8*BYTES-1:0] addr_i,
   input  logic [CRC_W-1:0]   crc_i,
   input  logic [8*BYTES-1:0] station_i,
   input  logic [TBL-1:0]     ind_tbl_i,
   input  logic [TBL-1:0]     grp_tbl_i,
   input  ctrl_t              ctrl_i,
   output verdict_t           verdict_o
);
   logic [HASH_BITS-1:0] idx;
   logic is_bc, is_grp, is_mc, sta_hit, class_hit, keep;

   assign idx     = crc_i[CRC_W-1 -: HASH_BITS];
   assign is_bc   = &addr_i;
   assign is_grp  = addr_i[0];
   assign is_mc   = is_grp && !is_bc;
   assign sta_hit = !is_grp && (addr_i == station_i);

   always_comb begin
      if (is_bc)      class_hit = !ctrl_i.bc_rej;
      else if (is_mc) class_hit = grp_tbl_i[idx];
      else            class_hit = sta_hit || ind_tbl_i[idx];
   end

   assign keep              = ctrl_i.prom || class_hit;
   assign verdict_o.accept  = keep;
   assign verdict_o.bcast   = keep && is_bc;
   assign verdict_o.mcast   = keep && is_mc;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import afl_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int CFG_W      = 32,
   parameter int SEL_W      = 3,
   parameter int HASH_BITS  = 6,
   parameter int CRC_W      = 32,
   parameter logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             addr_valid,
   input  logic [7:0]       addr_byte,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             dec_valid,
   output logic             accept,
   output logic             bcast_flag,
   output logic             mcast_flag
);
   localparam int TBL = 1 << HASH_BITS;
   localparam int AW  = 8 * ADDR_BYTES;

   if (CFG_W % 8 != 0) begin : g_bad_cfg_w
      $error("CFG_W must be a whole number of bytes");
   end
   if (ADDR_BYTES < 1 || ADDR_BYTES > 2 * (CFG_W / 8)) begin : g_bad_bytes
      $error("station address must fit in two configuration words");
   end
   if (TBL != 2 * CFG_W) begin : g_bad_tbl
      $error("hash table must span exactly two configuration words");
   end
   if (HASH_BITS > CRC_W) begin : g_bad_hash
      $error("hash index wider than CRC");
   end
   if (SEL_W < 3) begin : g_bad_sel
      $error("select too narrow for the register set");
   end

   logic           last_w;
   logic [AW-1:0]  addr_w, station_w;
   logic [CRC_W-1:0] crc_w;
   logic [TBL-1:0] ind_w, grp_w;
   ctrl_t          ctrl_w;
   verdict_t       verdict_w, verdict_q;
   logic           dv_q;

   afl_collect #(.BYTES(ADDR_BYTES), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_collect (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(frame_start),
      .valid_i(addr_valid),
      .byte_i (addr_byte),
      .last_o (last_w),
      .addr_o (addr_w),
      .crc_o  (crc_w)
   );

   afl_regs #(.BYTES(ADDR_BYTES), .CFG_W(CFG_W), .SEL_W(SEL_W), .TBL(TBL)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (cfg_we),
      .sel_i    (cfg_sel),
      .wdata_i  (cfg_wdata),
      .station_o(station_w),
      .ind_tbl_o(ind_w),
      .grp_tbl_o(grp_w),
      .ctrl_o   (ctrl_w)
   );

   afl_decide #(.BYTES(ADDR_BYTES), .CRC_W(CRC_W), .HASH_BITS(HASH_BITS), .TBL(TBL)) u_decide (
      .addr_i   (addr_w),
      .crc_i    (crc_w),
      .station_i(station_w),
      .ind_tbl_i(ind_w),
      .grp_tbl_i(grp_w),
      .ctrl_i   (ctrl_w),
      .verdict_o(verdict_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q      <= 1'b0;
         verdict_q <= '0;
      end else if (last_w) begin
         dv_q      <= 1'b1;
         verdict_q <= verdict_w;
      end else if (frame_start) begin
         dv_q      <= 1'b0;
         verdict_q <= '0;
      end
   end

   assign dec_valid  = dv_q;
   assign accept     = verdict_q.accept;
   assign bcast_flag = verdict_q.bcast;
   assign mcast_flag = verdict_q.mcast;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
   parameter int ADDR_BYTES = 6
) (
   input logic clk,
   input logic rst_n,
   input logic frame_start,
   input logic addr_valid,
   input logic dec_valid,
   input logic accept,
   input logic bcast_flag,
   input logic mcast_flag,
   input logic ctl_prom
);
   AST_RISE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(addr_valid)); // R2

   AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !frame_start) |=> (dec_valid && $stable(accept) && $stable(bcast_flag) && $stable(mcast_flag))); // R2

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && ADDR_BYTES > 1) |=> !dec_valid); // R2

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bcast_flag, mcast_flag})); // R9

   AST_FLAG_NEEDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_flag || mcast_flag) |-> (accept && dec_valid)); // R9

   AST_PROM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dec_valid) && $past(ctl_prom)) |-> accept); // R7
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_start(frame_start),
   .addr_valid (addr_valid),
   .dec_valid  (dec_valid),
   .accept     (accept),
   .bcast_flag (bcast_flag),
   .mcast_flag (mcast_flag),
   .ctl_prom   (ctrl_w.prom)
);

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYC    = 150000;

   logic        clk, rst_n, frame_start, addr_valid, cfg_we;
   logic [7:0]  addr_byte;
   logic [2:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        dec_valid, accept, bcast_flag, mcast_flag;

   int n_chk = 0;
   int n_err = 0;

   logic [47:0] m_sta;
   logic [63:0] m_ind, m_grp;
   logic        m_prom, m_brej;

   rx_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr_valid(addr_valid),
      .addr_byte(addr_byte), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .dec_valid(dec_valid), .accept(accept), .bcast_flag(bcast_flag), .mcast_flag(mcast_flag)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   // R4: reflected CRC-32, all-ones start, no final inversion
   function automatic logic [31:0] crc_of(input logic [47:0] a);
      logic [31:0] c = '1;
      for (int k = 0; k < 48; k++) begin
         logic fb = c[0] ^ a[k];
         c = c >> 1;
         if (fb) c = c ^ 32'hEDB88320;
      end
      return c;
   endfunction

   function automatic int idx_of(input logic [47:0] a);
      logic [31:0] c = crc_of(a);
      return int'(c[31:26]);
   endfunction

   function automatic logic [2:0] expect_of(input logic [47:0] a);
      int  ix = idx_of(a);
      logic bc = (a == '1);
      logic mc = a[0] && !bc;
      logic hit;
      if (m_prom)  hit = 1'b1;
      else if (bc) hit = !m_brej;
      else if (mc) hit = m_grp[ix];
      else         hit = (a == m_sta) || m_ind[ix];
      return {hit, bc && hit, mc && hit};
   endfunction

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         3'd0: m_sta[31:0]  = {d[7:0], d[15:8], d[23:16], d[31:24]};
         3'd1: m_sta[47:32] = {d[23:16], d[31:24]};
         3'd2: m_ind[31:0]  = d;
         3'd3: m_ind[63:32] = d;
         3'd4: m_grp[31:0]  = d;
         3'd5: m_grp[63:32] = d;
         3'd6: begin m_prom = d[0]; m_brej = d[1]; end
         default: ;
      endcase
   endtask

   task automatic set_station(input logic [47:0] a);
      cfg_write(3'd0, {a[7:0], a[15:8], a[23:16], a[31:24]});
      cfg_write(3'd1, {a[39:32], a[47:40], 16'h0000});
   endtask

   task automatic set_tables(input logic [63:0] ind, input logic [63:0] grp);
      cfg_write(3'd2, ind[31:0]);
      cfg_write(3'd3, ind[63:32]);
      cfg_write(3'd4, grp[31:0]);
      cfg_write(3'd5, grp[63:32]);
   endtask

   task automatic run_frame(input logic [47:0] a, input int junk, input int extra,
                            input logic gaps, input string req);
      logic [2:0] e = expect_of(a);
      if (junk > 0) begin
         @(negedge clk);
         frame_start = 1'b1; addr_valid = 1'b0;
         for (int j = 0; j < junk; j++) begin
            @(negedge clk);
            frame_start = 1'b0; addr_valid = 1'b1; addr_byte = 8'($urandom);
         end
      end
      @(negedge clk);
      frame_start = 1'b1; addr_valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
         int g = gaps ? $urandom_range(0, 2) : 0;
         @(negedge clk);
         frame_start = 1'b0; addr_valid = 1'b0;
         repeat (g) @(negedge clk);
         if (k == 5) chk({req, " R2 early"}, {31'd0, dec_valid}, 32'd0);
         addr_valid = 1'b1; addr_byte = a[8*k +: 8];
      end
      @(negedge clk);
      addr_valid = 1'b0;
      chk({req, " R2 valid"}, {31'd0, dec_valid}, 32'd1);
      chk(req, {29'd0, accept, bcast_flag, mcast_flag}, {29'd0, e});
      for (int x = 0; x < extra; x++) begin
         addr_valid = 1'b1; addr_byte = 8'($urandom);
         @(negedge clk);
         addr_valid = 1'b0;
         chk({req, " R1 extra bytes ignored"}, {28'd0, dec_valid, accept, bcast_flag, mcast_flag},
             {28'd0, 1'b1, e});
      end
   endtask

   initial begin
      repeat (MAX_CYC) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [47:0] a, hi_a, lo_a;
      logic found_hi, found_lo;
      void'($urandom(32'd7321));
      m_sta = '0; m_ind = '0; m_grp = '0; m_prom = 1'b0; m_brej = 1'b0;
      rst_n = 1'b0; frame_start = 1'b0; addr_valid = 1'b0; addr_byte = '0;
      cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset outputs", {28'd0, dec_valid, accept, bcast_flag, mcast_flag}, 32'd0);

      // R10 reset: all-zero tables and station; a random unicast is dropped
      run_frame(48'h5A4B3C2D1E02, 0, 0, 1'b0, "R10 reset tables empty");

      // R3: station match with empty tables, packing per R10
      set_station(48'h554433221102);
      run_frame(48'h554433221102, 0, 0, 1'b0, "R3 station hit");
      run_frame(48'h564433221102, 0, 0, 1'b0, "R3 R6 last byte differs");
      run_frame(48'h554433221103, 0, 0, 1'b0, "R1 group bit from byte0 bit0");

      // R4 R6: individual table at the exact index vs. its neighbour
      a = 48'h0F0E0D0C0B0A;
      set_tables(64'd1 << idx_of(a), '0);
      run_frame(a, 0, 0, 1'b0, "R4 R6 index hit");
      set_tables(64'd1 << (idx_of(a) ^ 1), '0);
      run_frame(a, 0, 0, 1'b0, "R4 R6 neighbour bit");

      // R5: group table split across words
      found_hi = 1'b0; found_lo = 1'b0; hi_a = '0; lo_a = '0;
      for (int b = 0; b < 256; b++) begin
         logic [47:0] t = {8'(b), 40'h00005E0001};
         if (!found_hi && idx_of(t) >= 32) begin hi_a = t; found_hi = 1'b1; end
         if (!found_lo && idx_of(t) < 32)  begin lo_a = t; found_lo = 1'b1; end
      end
      set_tables('0, 64'd1 << idx_of(hi_a));
      run_frame(hi_a, 0, 2, 1'b1, "R5 R9 group high word");
      run_frame(lo_a, 0, 0, 1'b0, "R5 group low word clear");
      set_tables('0, 64'd1 << idx_of(lo_a));
      run_frame(lo_a, 0, 0, 1'b0, "R5 R9 group low word");
      set_tables(64'd1 << idx_of(hi_a), '0);
      run_frame(hi_a, 0, 0, 1'b0, "R5 individual table unused");

      // R8 R9: broadcast
      run_frame('1, 0, 1, 1'b0, "R8 R9 broadcast kept");
      cfg_write(3'd6, 32'h2);
      run_frame('1, 0, 0, 1'b0, "R8 R9 broadcast rejected");
      cfg_write(3'd6, 32'h3);
      run_frame('1, 0, 0, 1'b0, "R7 R8 reject under prom");
      run_frame(48'h998877665544, 0, 0, 1'b0, "R7 prom unicast miss");
      cfg_write(3'd6, 32'h0);

      // R10: select 7 ignored
      cfg_write(3'd7, 32'hFFFFFFFF);
      set_tables('0, '0);
      run_frame(48'h998877665544, 0, 0, 1'b0, "R10 select 7 ignored");

      // R2: restart mid-frame
      run_frame(48'h554433221102, 3, 1, 1'b1, "R2 R3 restart mid-frame");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int cls;
         if (n % 25 == 0) begin
            set_station({$urandom, 16'($urandom)} & 48'hFFFFFFFFFFFE);
            set_tables({$urandom, $urandom}, {$urandom, $urandom});
            cfg_write(3'd6, {30'd0, ($urandom_range(0, 1) == 1), ($urandom_range(0, 7) == 0)});
         end
         cls = $urandom_range(0, 4);
         case (cls)
            0: a = m_sta;
            1: a = '1;
            2: a = {$urandom, 16'($urandom)} | 48'h1;
            3: a = {$urandom, 16'($urandom)} & 48'hFFFFFFFFFFFE;
            default: a = {$urandom, 16'($urandom)};
         endcase
         run_frame(a, (n % 7 == 0) ? 2 : 0, n % 2, 1'b1, "R3 R4 R5 R6 R7 R8 R9 random");
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule